// File: doc/BRIEF.md
# Parallel PRBS-15 Word Error Checker

This block verifies that a stream of parallel data words carries an unbroken PRBS-15 pattern. The sequence obeys the recurrence b[n] = b[n-14] XOR b[n-15], which corresponds to the polynomial x^15 + x^14 + 1. Words arrive on a fixed-width bus, and the earliest bit of each word sits in bit 0. The checker looks at a word only in a cycle where the word-enable input is high. It takes its starting state from the first bits it receives. After that it predicts every following word and compares the received word with the prediction.

Two flags report the result. The real-time flag is high for one cycle after each word that contains a mismatch. The sticky flag goes high with the first mismatch and stays high until a clear pulse re-arms it. The project also contains a companion serial pattern source. This source emits one bit per clock and has a force-error request input that inverts a single bit, so the detection path can be exercised from end to end.

Top module: `prbs15_word_checker`

## Requirements
- R1: The expected sequence satisfies b[n] = b[n-14] XOR b[n-15]. Within a word, bit 0 is the earliest bit and bit WORD_W-1 is the latest.
- R2: After reset, the first ceil(15/WORD_W) enabled words are loaded as the starting state and are never flagged (two words for WORD_W = 10). From then on every enabled word is checked, whatever the phase of the incoming sequence, until the next reset.
- R3: After synchronisation, rt_err is high in the cycle after an enabled word in which one or more bits differ from the prediction. It is low in the cycle after an enabled word that matches the prediction.
- R4: The prediction runs on from the predicted sequence and not from the received bits. A word with corrupted bits is flagged once, and the next correct word is not flagged.
- R5: A cycle with word_en low is ignored. word_in may hold any value in that cycle, the prediction state does not advance, and rt_err is low in the following cycle.
- R6: err_sticky is set on the same edge as any rt_err and stays high while err_clr is low.
- R7: err_clr high in a cycle clears err_sticky at the next edge. If a flagged word is checked in that same cycle, the set takes priority and err_sticky stays high.
- R8: While rst_n is low (asynchronous, active low), rt_err and err_sticky are low and the checker is unsynchronised.
- R9: The companion source emits one bit per clock following R1, starting from a non-zero seed. Its shift register is never all zero.
- R10: Each rising edge of the source's force_err input inverts exactly one emitted bit, namely the bit registered on that edge. Holding force_err high inverts nothing more, so exactly one checked word is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | WORD_W | Received word, bit 0 earliest |
| word_en | input | 1 | High when word_in holds a word to process |
| err_clr | input | 1 | Re-arm pulse for the sticky flag |
| rt_err | output | 1 | High for one cycle after a mismatching word |
| err_sticky | output | 1 | Latched error flag, cleared by err_clr |

## Verification
The properties assume that word_en and err_clr are synchronous to clk and always defined. They also assume that reset is asserted from time zero. They make no assumption about word_in in idle cycles, and the companion-source property takes a non-zero seed as given. The bench changes every input half a period away from the rising edge. It drives random garbage onto word_in whenever word_en is low, and it holds force_err high for several cycles so that only its rising edge counts as a request. A reference model built from the recurrence then decides, word by word, which words must be flagged.

// File: rtl/prbs15_pkg.sv
package prbs15_pkg;

    localparam int PRBS_ORDER = 15;
    localparam int PRBS_TAP   = 14;

    typedef logic [PRBS_ORDER-1:0] prbs_state_t;

    // bit 0 holds the newest bit, bit k the bit k+1 positions back
    function automatic logic prbs_next_bit(prbs_state_t s);
        return s[PRBS_TAP-1] ^ s[PRBS_ORDER-1];
    endfunction

    function automatic prbs_state_t prbs_push(prbs_state_t s, logic b);
        return {s[PRBS_ORDER-2:0], b};
    endfunction

endpackage

// File: rtl/prbs15_word_predict.sv
module prbs15_word_predict
    import prbs15_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  prbs_state_t       hist_i,
    input  logic [WORD_W-1:0] rx_word_i,
    output logic [WORD_W-1:0] exp_word_o,
    output prbs_state_t       hist_pred_o,
    output prbs_state_t       hist_rx_o
);

    prbs_state_t pred_chain [WORD_W+1];
    prbs_state_t rx_chain   [WORD_W+1];

    assign pred_chain[0] = hist_i;
    assign rx_chain[0]   = hist_i;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign exp_word_o[i]   = prbs_next_bit(pred_chain[i]);
        assign pred_chain[i+1] = prbs_push(pred_chain[i], exp_word_o[i]);
        assign rx_chain[i+1]   = prbs_push(rx_chain[i], rx_word_i[i]);
    end

    assign hist_pred_o = pred_chain[WORD_W];
    assign hist_rx_o   = rx_chain[WORD_W];

endmodule

// File: rtl/prbs15_word_compare.sv
module prbs15_word_compare #(
    parameter int WORD_W = 10
) (
    input  logic [WORD_W-1:0] exp_word_i,
    input  logic [WORD_W-1:0] rx_word_i,
    output logic              mismatch_o
);

    logic [WORD_W-1:0] bit_diff;

    assign bit_diff   = exp_word_i ^ rx_word_i;
    assign mismatch_o = |bit_diff;

endmodule

// File: rtl/prbs15_serial_gen.sv
module prbs15_serial_gen
    import prbs15_pkg::*;
#(
    parameter prbs_state_t SEED = 15'h7FFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_err,
    output logic bit_out
);

    localparam logic        FIRST_BIT = prbs_next_bit(SEED);
    localparam prbs_state_t START     = prbs_push(SEED, FIRST_BIT);

    typedef struct packed {
        prbs_state_t lfsr;
        logic        force_prev;
        logic        out;
    } gen_regs_t;

    gen_regs_t   d, q;
    logic        fb;
    prbs_state_t lfsr_q;

    always_comb begin
        d            = q;
        fb           = prbs_next_bit(q.lfsr);
        d.lfsr       = prbs_push(q.lfsr, fb);
        d.force_prev = force_err;
        d.out        = fb ^ (force_err & ~q.force_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lfsr       <= START;
            q.force_prev <= 1'b0;
            q.out        <= FIRST_BIT;
        end else begin
            q <= d;
        end
    end

    assign bit_out = q.out;
    assign lfsr_q  = q.lfsr;

endmodule

// File: rtl/prbs15_word_checker.sv
module prbs15_word_checker
    import prbs15_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_en,
    input  logic              err_clr,
    output logic              rt_err,
    output logic              err_sticky
);

    localparam int                FILL_W    = $clog2(PRBS_ORDER + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(PRBS_ORDER);

    typedef struct packed {
        prbs_state_t       hist;
        logic [FILL_W-1:0] fill;
        logic              rt;
        logic              sticky;
    } chk_regs_t;

    chk_regs_t         d, q;
    logic [WORD_W-1:0] exp_word;
    prbs_state_t       hist_pred;
    prbs_state_t       hist_rx;
    logic              word_bad;
    logic              locked;
    int                fill_sum;

    prbs15_word_predict #(.WORD_W(WORD_W)) u_predict (
        .hist_i      (q.hist),
        .rx_word_i   (word_in),
        .exp_word_o  (exp_word),
        .hist_pred_o (hist_pred),
        .hist_rx_o   (hist_rx)
    );

    prbs15_word_compare #(.WORD_W(WORD_W)) u_compare (
        .exp_word_i (exp_word),
        .rx_word_i  (word_in),
        .mismatch_o (word_bad)
    );

    assign locked = (q.fill == FILL_FULL);

    always_comb begin
        d        = q;
        d.rt     = 1'b0;
        fill_sum = int'(q.fill) + WORD_W;
        if (word_en) begin
            if (!locked) begin
                // seeding: received bits become the history
                d.hist = hist_rx;
                d.fill = (fill_sum >= PRBS_ORDER) ? FILL_FULL : FILL_W'(fill_sum);
            end else begin
                // checking: history runs on from the prediction
                d.hist = hist_pred;
                d.rt   = word_bad;
            end
        end
        d.sticky = d.rt | (q.sticky & ~err_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rt_err     = q.rt;
    assign err_sticky = q.sticky;

endmodule

// File: rtl/prbs15_word_checker_sva.sv
module prbs15_word_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic word_en,
    input logic err_clr,
    input logic rt_err,
    input logic err_sticky,
    input logic locked
);

    assert_flag_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rt_err |-> $past(word_en));

    assert_idle_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_en |=> !rt_err);

    assert_seed_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_en && !locked) |=> !rt_err);

    assert_lock_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_sticky_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rt_err |-> err_sticky);

    assert_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_sticky) && !$past(err_clr)) |-> err_sticky);

    assert_sticky_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> rt_err);

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_clr) && !rt_err) |-> !err_sticky);

endmodule

module prbs15_gen_sva
    import prbs15_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input prbs_state_t lfsr_state
);

    assert_state_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

endmodule

bind prbs15_word_checker prbs15_word_checker_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_en    (word_en),
    .err_clr    (err_clr),
    .rt_err     (rt_err),
    .err_sticky (err_sticky),
    .locked     (locked)
);

bind prbs15_serial_gen prbs15_gen_sva u_gen_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .lfsr_state (lfsr_q)
);

// File: tb/prbs15_word_checker_test.sv
module prbs15_word_checker_test;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         word_en = 1'b0;
    logic         err_clr = 1'b0;
    logic         force_err = 1'b0;
    logic         rt_err;
    logic         err_sticky;
    logic         gen_bit;

    always #5 clk = ~clk;

    prbs15_word_checker #(.WORD_W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_in    (word_in),
        .word_en    (word_en),
        .err_clr    (err_clr),
        .rt_err     (rt_err),
        .err_sticky (err_sticky)
    );

    prbs15_serial_gen gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_err (force_err),
        .bit_out   (gen_bit)
    );

    int checks = 0;
    int fails = 0;
    int gen_diffs = 0;
    int flag_count = 0;
    bit done = 0;
    bit model_sticky = 0;
    bit rxq[$];
    bit mpred[$];
    bit gpred[$];

    // collect source bits away from the edge; compare with an ideal sequence
    always @(negedge clk) begin
        if (rst_n) begin
            rxq.push_back(gen_bit);
            if (gpred.size() < 15) begin
                gpred.push_back(gen_bit);
            end else begin
                int n;
                bit p;
                n = gpred.size();
                p = gpred[n-14] ^ gpred[n-15];
                gpred.push_back(p);
                if (p != gen_bit) gen_diffs++;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference: expected flag for one enabled word per R1/R2/R4
    function automatic bit model_word(logic [W-1:0] w);
        bit bad;
        bad = 0;
        if (mpred.size() < 15) begin
            for (int i = 0; i < W; i++) mpred.push_back(w[i]);
        end else begin
            for (int i = 0; i < W; i++) begin
                int n;
                bit p;
                n = mpred.size();
                p = mpred[n-14] ^ mpred[n-15];
                mpred.push_back(p);
                if (p != w[i]) bad = 1;
            end
        end
        return bad;
    endfunction

    // caller is at a falling edge; drive, advance one clock, check
    task automatic step(bit en, logic [W-1:0] w, bit clr, string req);
        bit exp_rt;
        word_en = en;
        word_in = w;
        err_clr = clr;
        exp_rt = en ? model_word(w) : 1'b0;
        model_sticky = exp_rt | (model_sticky & !clr);
        @(negedge clk);
        if (rt_err) flag_count++;
        check({req, " rt_err"}, int'(rt_err), int'(exp_rt));
        check("R6 err_sticky", int'(err_sticky), int'(model_sticky));
    endtask

    task automatic get_word(output logic [W-1:0] w);
        while (rxq.size() < W) step(1'b0, W'($urandom), 1'b0, "R5");
        for (int i = 0; i < W; i++) w[i] = rxq.pop_front();
    endtask

    task automatic send_words(int count, logic [W-1:0] flip, string req);
        for (int k = 0; k < count; k++) begin
            logic [W-1:0] w;
            get_word(w);
            step(1'b1, w ^ flip, 1'b0, req);
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #2;
        word_en = 1'b0;
        err_clr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rxq.delete();
        mpred.delete();
        gpred.delete();
        model_sticky = 0;
        check("R8 rt_err in reset", int'(rt_err), 0);
        check("R8 err_sticky in reset", int'(err_sticky), 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] w;
        repeat (3) @(negedge clk);
        check("R8 rt_err at start", int'(rt_err), 0);
        check("R8 err_sticky at start", int'(err_sticky), 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);

        // R5: garbage while idle before seeding
        for (int k = 0; k < 4; k++) step(1'b0, W'($urandom), 1'b0, "R5");
        // R2: two seeding words, then R1/R3 clean checked words
        send_words(2, '0, "R2");
        send_words(12, '0, "R3");
        check("R9 source follows recurrence", gen_diffs, 0);
        check("R3 no flags on clean stream", flag_count, 0);

        // R10: force held high for several cycles -> one bit, one word
        flag_count = 0;
        force_err = 1'b1;
        step(1'b0, W'($urandom), 1'b0, "R5");
        step(1'b0, W'($urandom), 1'b0, "R5");
        step(1'b0, W'($urandom), 1'b0, "R5");
        force_err = 1'b0;
        send_words(6, '0, "R4");
        check("R10 one flagged word", flag_count, 1);
        check("R10 one inverted bit", gen_diffs, 1);

        // R6: sticky kept across idle cycles
        for (int k = 0; k < 5; k++) step(1'b0, W'($urandom), 1'b0, "R6");
        // R7: clear alone
        step(1'b0, W'($urandom), 1'b1, "R7");
        check("R7 cleared", int'(err_sticky), 0);

        // R7: error and clear in the same cycle, set wins
        get_word(w);
        step(1'b1, w ^ W'(10'h201), 1'b1, "R7");
        check("R7 set over clear", int'(err_sticky), 1);
        send_words(2, '0, "R4");
        step(1'b0, W'($urandom), 1'b1, "R7");

        // R3: every bit wrong, then R4 recovery
        send_words(1, '1, "R3");
        send_words(2, '0, "R4");

        // R5: garbage after lock must not advance prediction
        for (int k = 0; k < 6; k++) step(1'b0, W'($urandom), 1'b0, "R5");
        send_words(3, '0, "R5");

        // R8/R2: reset mid-run, reseed at an arbitrary phase
        do_reset();
        for (int k = 0; k < 7; k++) step(1'b0, W'($urandom), 1'b0, "R5");
        repeat (7) void'(rxq.pop_front());
        flag_count = 0;
        send_words(2, '0, "R2");
        send_words(8, '0, "R2");
        check("R2 clean after reseed", flag_count, 0);
        check("R9 no extra inversions", gen_diffs, 1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

endmodule